// File: doc/BRIEF.md
# Two-Phase Microinstruction Sequencer and Decoder

This block drives a 16-bit horizontal microinstruction machine. The machine runs in two alternating phases. In the fetch phase the decoder ignores the instruction register. It issues a fixed fetch word instead. That word reads memory at the program counter (register 7) and increments it through the ALU with a carry-in of one. The word read from memory is then loaded into the instruction register. In the execute phase the decoder breaks the word held in the instruction register into its fields and sends each field to the datapath as a control signal.

The block holds the carry and equal status flags. It latches them from the ALU only when an instruction asks for it. Logic-mode ALU operations make no use of a carry input, so the block gives the carry-in select field a second meaning in that mode: it gates the register-file writeback on a latched flag, or blocks the writeback entirely. This gives conditional jumps (a conditional move into the program counter) and compares that leave the operand register unchanged. When an instruction sets both the memory-read bit and the memory-write bit, the cycle becomes a control cycle. Memory and register-file access are then suppressed, and the data-side register field is emitted as a strobe index.

Instruction layout (bit positions are decoded by neighbours and kept fixed): bit 15 memory read, bit 14 memory write, bits 13:11 A-side register, bits 10:8 B-side register, bit 7 hold-status (active low: 0 means latch), bits 6:5 carry-in select, bits 4:0 ALU function. Bit 4 high selects logic mode.

Top module: `useq_decode`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, the phase output is 0 (fetch) and both latched flags are 0.
- R2: Once reset has been released, phase_o inverts on every rising clock edge: 0 is fetch and 1 is execute.
- R3: In fetch the outputs take their values from the fixed word 0xBF80, whatever instr_i holds: mem_rd_o=1, mem_wr_o=0, a_sel_o=7, b_sel_o=7, stat_latch_o=0, carry_in_o=1, alu_fn_o=0, rf_we_o=0, ir_load_o=1, ctl_cycle_o=0, ctl_idx_o=0.
- R4: In execute, a_sel_o=instr_i[13:11], b_sel_o=instr_i[10:8] and alu_fn_o=instr_i[4:0]. Outside a control cycle, mem_rd_o=instr_i[15] and mem_wr_o=instr_i[14].
- R5: carry_in_o is set by select bits [6:5] as follows: 00 gives 1, 01 gives the latched carry flag, 10 gives the latched equal flag, 11 gives 0.
- R6: At a rising edge in execute with instr_i[7]=0, the flags load alu_cy_i and alu_eq_i. At every other edge they hold their value. stat_latch_o is high exactly when execute and instr_i[7]=0 are both true.
- R7: In an execute cycle that is not a control cycle and has instr_i[4]=0 (arithmetic), rf_we_o=1 for every select value.
- R8: In an execute cycle that is not a control cycle and has instr_i[4]=1 (logic), rf_we_o follows the select bits: 00 gives 1, 01 gives the carry flag, 10 gives the equal flag, 11 gives 0.
- R9: In execute with instr_i[15]=instr_i[14]=1, ctl_cycle_o=1 and ctl_idx_o=instr_i[10:8], while mem_rd_o, mem_wr_o and rf_we_o are 0. In every other cycle ctl_cycle_o=0 and ctl_idx_o=0.
- R10: ir_load_o is 1 in fetch and 0 in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Instruction register contents |
| alu_cy_i | input | 1 | Carry result from the ALU |
| alu_eq_i | input | 1 | Equal result from the ALU |
| phase_o | output | 1 | Current phase, 0 fetch, 1 execute |
| ir_load_o | output | 1 | Capture the data bus into the instruction register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| a_sel_o | output | 3 | A-side (address bus, ALU A) register select |
| b_sel_o | output | 3 | B-side (data bus, ALU B) register select |
| stat_latch_o | output | 1 | Status flag latch enable |
| carry_in_o | output | 1 | Carry input to the ALU |
| alu_fn_o | output | 5 | ALU function |
| rf_we_o | output | 1 | Register-file write of the ALU result |
| ctl_cycle_o | output | 1 | Control cycle active |
| ctl_idx_o | output | 3 | Control strobe index |
| flag_cy_o | output | 1 | Latched carry flag |
| flag_eq_o | output | 1 | Latched equal flag |

## Verification
Directed words run logic-mode writes under all four select values, with each flag first latched set and then latched clear. These runs separate the carry-gated writeback from the equal-gated one, and both from the forced write and the forced inhibit. Arithmetic words that use the same select values confirm that the writeback gating applies only in logic mode. Words that set both memory bits, or only one of them, separate the control cycle from plain memory reads and writes. A long random run applies junk to instr_i during fetch and toggles the latch bit, so any leak of the instruction register into fetch, or any flag update on a non-latching cycle, shows up on the next compare.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int WORD_W = 16;
  localparam int RSEL_W = 3;
  localparam int FN_W   = 5;
  localparam int CSEL_W = 2;
  localparam int LOGIC_BIT = FN_W - 1;

  typedef enum logic [CSEL_W-1:0] {
    CIN_ONE  = 2'b00,
    CIN_CY   = 2'b01,
    CIN_EQ   = 2'b10,
    CIN_ZERO = 2'b11
  } cin_sel_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [RSEL_W-1:0] a_reg;
    logic [RSEL_W-1:0] b_reg;
    logic              hold_n;
    cin_sel_e          csel;
    logic [FN_W-1:0]   fn;
  } uword_t;

  localparam uword_t FETCH_WORD = uword_t'(16'hBF80);

endpackage

// File: rtl/useq_phase.sv
module useq_phase
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e phase_q;
  phase_e phase_d;
  logic   phase_en;

  assign phase_en = 1'b1;

  always_comb begin
    phase_d = phase_q;
    if (phase_en) begin
      phase_d = (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase_q != $past(phase_q))); // R2

  AST_PHASE_RST: assert property (@(posedge clk)
    !rst_n |-> (phase_q == PH_FETCH)); // R1

endmodule

// File: rtl/useq_flags.sv
module useq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_en_i,
  input  logic cy_i,
  input  logic eq_i,
  output logic cy_o,
  output logic eq_o
);

  logic cy_q, eq_q;
  logic cy_d, eq_d;

  always_comb begin
    cy_d = cy_q;
    eq_d = eq_q;
    if (latch_en_i) begin
      cy_d = cy_i;
      eq_d = eq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      eq_q <= 1'b0;
    end else begin
      cy_q <= cy_d;
      eq_q <= eq_d;
    end
  end

  assign cy_o = cy_q;
  assign eq_o = eq_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(latch_en_i)) |-> ($stable(cy_q) && $stable(eq_q))); // R6

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(latch_en_i)) |-> (cy_q == $past(cy_i) && eq_q == $past(eq_i))); // R6

endmodule

// File: rtl/useq_field_dec.sv
module useq_field_dec
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              flag_cy_i,
  input  logic              flag_eq_i,
  output logic              ir_load_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [RSEL_W-1:0] a_sel_o,
  output logic [RSEL_W-1:0] b_sel_o,
  output logic              latch_en_o,
  output logic              carry_in_o,
  output logic [FN_W-1:0]   alu_fn_o,
  output logic              wb_o,
  output logic              ctl_o,
  output logic [RSEL_W-1:0] ctl_idx_o
);

  uword_t word;
  logic   in_exec;
  logic   logic_mode;
  logic   sel_truth;

  // Source word: the fixed fetch word or the instruction register
  always_comb begin
    if (phase_i == PH_FETCH) begin
      word = FETCH_WORD;
    end else begin
      word = uword_t'(instr_i);
    end
  end

  assign in_exec    = (phase_i == PH_EXEC);
  assign logic_mode = word.fn[LOGIC_BIT];

  // One truth table serves both the carry input and the write condition
  always_comb begin
    unique case (word.csel)
      CIN_ONE:  sel_truth = 1'b1;
      CIN_CY:   sel_truth = flag_cy_i;
      CIN_EQ:   sel_truth = flag_eq_i;
      default:  sel_truth = 1'b0;
    endcase
  end

  always_comb begin
    ctl_o      = in_exec & word.rd & word.wr;
    mem_rd_o   = word.rd & ~ctl_o;
    mem_wr_o   = word.wr & ~ctl_o;
    a_sel_o    = word.a_reg;
    b_sel_o    = word.b_reg;
    alu_fn_o   = word.fn;
    carry_in_o = sel_truth;
    latch_en_o = in_exec & ~word.hold_n;
    ir_load_o  = ~in_exec;
    ctl_idx_o  = ctl_o ? word.b_reg : '0;
    if (!in_exec || ctl_o) begin
      wb_o = 1'b0;
    end else if (logic_mode) begin
      wb_o = sel_truth;
    end else begin
      wb_o = 1'b1;
    end
  end

  AST_FETCH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_FETCH) |-> (mem_rd_o && !mem_wr_o && a_sel_o == '1 && !wb_o && !latch_en_o && carry_in_o)); // R3

  AST_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o |-> (!mem_rd_o && !mem_wr_o && !wb_o && ctl_idx_o == instr_i[10:8])); // R9

  AST_NEVER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EXEC && instr_i[4] && instr_i[6:5] == 2'b11) |-> !wb_o); // R8

  AST_ARITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EXEC && !instr_i[4] && !(instr_i[15] && instr_i[14])) |-> wb_o); // R7

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load_o |-> !ctl_o && !wb_o); // R10

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
#(
  parameter bit WE_ACTIVE_LOW    = 1'b0,
  parameter bit LATCH_ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              alu_cy_i,
  input  logic              alu_eq_i,
  output logic              phase_o,
  output logic              ir_load_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [RSEL_W-1:0] a_sel_o,
  output logic [RSEL_W-1:0] b_sel_o,
  output logic              stat_latch_o,
  output logic              carry_in_o,
  output logic [FN_W-1:0]   alu_fn_o,
  output logic              rf_we_o,
  output logic              ctl_cycle_o,
  output logic [RSEL_W-1:0] ctl_idx_o,
  output logic              flag_cy_o,
  output logic              flag_eq_o
);

  phase_e phase;
  logic   latch_en;
  logic   wb;
  logic   cy_q, eq_q;

  useq_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  useq_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_en_i (latch_en),
    .cy_i       (alu_cy_i),
    .eq_i       (alu_eq_i),
    .cy_o       (cy_q),
    .eq_o       (eq_q)
  );

  useq_field_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase),
    .instr_i    (instr_i),
    .flag_cy_i  (cy_q),
    .flag_eq_i  (eq_q),
    .ir_load_o  (ir_load_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .a_sel_o    (a_sel_o),
    .b_sel_o    (b_sel_o),
    .latch_en_o (latch_en),
    .carry_in_o (carry_in_o),
    .alu_fn_o   (alu_fn_o),
    .wb_o       (wb),
    .ctl_o      (ctl_cycle_o),
    .ctl_idx_o  (ctl_idx_o)
  );

  // Polarity conversion happens only here, at the block edge
  generate
    if (WE_ACTIVE_LOW) begin : g_we_low
      assign rf_we_o = ~wb;
    end else begin : g_we_high
      assign rf_we_o = wb;
    end
    if (LATCH_ACTIVE_LOW) begin : g_latch_low
      assign stat_latch_o = ~latch_en;
    end else begin : g_latch_high
      assign stat_latch_o = latch_en;
    end
  endgenerate

  assign phase_o   = (phase == PH_EXEC);
  assign flag_cy_o = cy_q;
  assign flag_eq_o = eq_q;

endmodule

// File: tb/test_useq_decode.sv
module test_useq_decode;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RAND_CYCLES = 3000;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr;
  logic        alu_cy, alu_eq;
  logic        phase, ir_load, mem_rd, mem_wr, stat_latch, carry_in, rf_we, ctl, flag_cy, flag_eq;
  logic [2:0]  a_sel, b_sel, ctl_idx;
  logic [4:0]  alu_fn;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  int m_phase = 0;
  int m_cy    = 0;
  int m_eq    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_decode i_useq_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_i      (instr),
    .alu_cy_i     (alu_cy),
    .alu_eq_i     (alu_eq),
    .phase_o      (phase),
    .ir_load_o    (ir_load),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .a_sel_o      (a_sel),
    .b_sel_o      (b_sel),
    .stat_latch_o (stat_latch),
    .carry_in_o   (carry_in),
    .alu_fn_o     (alu_fn),
    .rf_we_o      (rf_we),
    .ctl_cycle_o  (ctl),
    .ctl_idx_o    (ctl_idx),
    .flag_cy_o    (flag_cy),
    .flag_eq_o    (flag_eq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(input bit rd, input bit wr, input int a, input int b,
                                     input bit hold_n, input int csel, input int fn);
    logic [15:0] w;
    w[15]    = rd;
    w[14]    = wr;
    w[13:11] = 3'(a);
    w[10:8]  = 3'(b);
    w[7]     = hold_n;
    w[6:5]   = 2'(csel);
    w[4:0]   = 5'(fn);
    return w;
  endfunction

  function automatic int sel_value(input int csel);
    case (csel)
      0:       return 1;
      1:       return m_cy;
      2:       return m_eq;
      default: return 0;
    endcase
  endfunction

  // Compare every output against the model for the current cycle
  task automatic compare();
    int rd, wr, cs, is_ctl, lg;
    check("R2", "phase", int'(phase), m_phase);
    check("R6", "flag_cy", int'(flag_cy), m_cy);
    check("R6", "flag_eq", int'(flag_eq), m_eq);
    if (m_phase == 0) begin
      check("R3", "mem_rd", int'(mem_rd), 1);
      check("R3", "mem_wr", int'(mem_wr), 0);
      check("R3", "a_sel", int'(a_sel), 7);
      check("R3", "b_sel", int'(b_sel), 7);
      check("R3", "stat_latch", int'(stat_latch), 0);
      check("R3", "carry_in", int'(carry_in), 1);
      check("R3", "alu_fn", int'(alu_fn), 0);
      check("R3", "rf_we", int'(rf_we), 0);
      check("R3", "ctl", int'(ctl), 0);
      check("R3", "ctl_idx", int'(ctl_idx), 0);
      check("R10", "ir_load", int'(ir_load), 1);
    end else begin
      rd = int'(instr[15]);
      wr = int'(instr[14]);
      cs = int'(instr[6:5]);
      lg = int'(instr[4]);
      is_ctl = rd & wr;
      check("R10", "ir_load", int'(ir_load), 0);
      check("R4", "a_sel", int'(a_sel), int'(instr[13:11]));
      check("R4", "b_sel", int'(b_sel), int'(instr[10:8]));
      check("R4", "alu_fn", int'(alu_fn), int'(instr[4:0]));
      check("R5", "carry_in", int'(carry_in), sel_value(cs));
      check("R6", "stat_latch", int'(stat_latch), instr[7] ? 0 : 1);
      if (is_ctl != 0) begin
        check("R9", "ctl", int'(ctl), 1);
        check("R9", "ctl_idx", int'(ctl_idx), int'(instr[10:8]));
        check("R9", "mem_rd", int'(mem_rd), 0);
        check("R9", "mem_wr", int'(mem_wr), 0);
        check("R9", "rf_we", int'(rf_we), 0);
      end else begin
        check("R9", "ctl", int'(ctl), 0);
        check("R9", "ctl_idx", int'(ctl_idx), 0);
        check("R4", "mem_rd", int'(mem_rd), rd);
        check("R4", "mem_wr", int'(mem_wr), wr);
        if (lg != 0) check("R8", "rf_we logic", int'(rf_we), sel_value(cs));
        else         check("R7", "rf_we arith", int'(rf_we), 1);
      end
    end
  endtask

  // One clock: drive just after a falling edge, compare, advance model at the rising edge
  task automatic step(input logic [15:0] w, input bit cy, input bit eq);
    instr  = w;
    alu_cy = cy;
    alu_eq = eq;
    #1;
    compare();
    @(posedge clk);
    if (m_phase == 1 && w[7] == 1'b0) begin
      m_cy = int'(cy);
      m_eq = int'(eq);
    end
    m_phase = 1 - m_phase;
    @(negedge clk);
  endtask

  // Fetch cycle with junk on the instruction bus, then an execute cycle
  task automatic pair(input logic [15:0] w, input bit cy, input bit eq);
    step(16'hFFFF ^ w, ~cy, ~eq);
    step(w, cy, eq);
  endtask

  initial begin
    rst_n  = 1'b0;
    instr  = 16'h0000;
    alu_cy = 1'b1;
    alu_eq = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "phase in reset", int'(phase), 0);
    check("R1", "flag_cy in reset", int'(flag_cy), 0);
    check("R1", "flag_eq in reset", int'(flag_eq), 0);
    rst_n = 1'b1;
    #1;
    check("R1", "phase after release", int'(phase), 0);

    // Latch carry set, equal clear (arithmetic, latching)
    pair(mk(0, 0, 1, 2, 0, 0, 5'h00), 1'b1, 1'b0);
    // Logic writes under each select with cy=1 eq=0
    pair(mk(0, 0, 3, 4, 1, 1, 5'h1B), 1'b0, 1'b1);   // R8 carry gate -> write
    pair(mk(0, 0, 3, 4, 1, 2, 5'h1B), 1'b0, 1'b1);   // R8 equal gate -> no write
    pair(mk(0, 0, 3, 4, 1, 3, 5'h16), 1'b0, 1'b1);   // R8 forced inhibit
    pair(mk(0, 0, 3, 4, 1, 0, 5'h16), 1'b0, 1'b1);   // R8 forced write
    // Latch carry clear, equal set
    pair(mk(0, 0, 0, 0, 0, 0, 5'h1F), 1'b0, 1'b1);
    pair(mk(0, 0, 7, 4, 1, 1, 5'h1A), 1'b1, 1'b0);   // R8 carry gate -> no write
    pair(mk(0, 0, 7, 4, 1, 2, 5'h1A), 1'b1, 1'b0);   // R8 equal gate -> jump taken
    // Arithmetic with every select still writes (R7)
    for (int c = 0; c < 4; c++) pair(mk(0, 0, 5, 6, 1, c, 5'h09), 1'b0, 1'b0);
    // Control cycles with each index (R9)
    for (int k = 0; k < 8; k++) pair(mk(1, 1, 2, k, 1, 0, 5'h00), 1'b1, 1'b1);
    // Plain memory read and write (R4)
    pair(mk(1, 0, 6, 1, 1, 0, 5'h0F), 1'b0, 1'b0);
    pair(mk(0, 1, 6, 1, 1, 2, 5'h1F), 1'b0, 1'b0);
    // Random traffic
    for (int i = 0; i < RAND_CYCLES; i++) begin
      step(16'($urandom), 1'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule